// File: doc/BRIEF.md
# Interrupt Presentation Priority Controller

This block is the per-processor end of an interrupt fabric. It holds the processor's current priority, the priority at which an inter-processor interrupt (IPI) is requested, and a single pending slot (source id plus priority). A deliver request places an interrupt in the slot. An accept request hands that interrupt to the processor. Priority writes and end-of-interrupt writes move the processor's priority up or down. The block drives one interrupt line toward the processor. Priorities are 8-bit, and a numerically lower value is more favoured.

Some requests displace an interrupt that is already pending, or find that an interrupt could not be placed earlier. The block then reports this outward on a notice channel with a valid/ready handshake, toward the source controller. It reports a REJECT notice for a displaced source, a RESEND notice when a failed delivery should be retried, and an EOI notice for a completed source. Every state update completes in the clock cycle that takes the request.

A small notice state machine controls the outbound side. In `NQ_IDLE` no notice is shown and requests are taken. When a taken request yields one notice, the machine moves to `NQ_ONE`. When it yields two notices, it moves to `NQ_TWO`. `NQ_TWO` goes to `NQ_ONE` on `note_ready`, and the queued notice becomes visible. `NQ_ONE` returns to `NQ_IDLE` on `note_ready`.

Top module: `ipp_presenter`

## Requirements
- R1: A synchronous active-low reset sets the processor priority to 0x00, the IPI priority to 0xFF and the pending priority to 0xFF. It clears the pending source id and the resend flag. After reset `acc_word` reads 0, `irq_out` and `note_valid` are low, and `acc_ready` is high.
- R2: `irq_out` is high exactly when the pending source id is nonzero and the pending priority is strictly below the processor priority.
- R3: A delivery succeeds only if its priority is strictly below the processor priority, the IPI priority and the pending priority. On success the new id and priority fill the slot. A displaced nonzero, non-IPI id is reported as a REJECT notice (kind code 1).
- R4: A failed delivery leaves the slot unchanged and sets the resend flag.
- R5: `acc_word` shows the processor priority in bits 31:24 and the pending source id in bits 23:0. When an accept is taken with a nonzero id pending, the processor priority takes the pending priority, the id becomes 0 and the pending priority becomes 0xFF. With no id pending, an accept changes nothing.
- R6: Source id 2 is the IPI. An IPI-priority write makes id 2 pending at the new IPI priority whenever that priority is strictly below the processor priority and not above the pending priority. A lowering of the processor priority does the same using the stored IPI priority. Id 2 and id 0 are never reported as REJECT.
- R7: Writing a processor priority below the current one loads it. If the new value is not above the pending priority, the pending id is displaced (REJECT notice if nonzero and not the IPI), the id becomes 0 and the pending priority becomes 0xFF.
- R8: Writing a processor priority above the current one loads it, applies the IPI check of R6 and clears the resend flag, issuing a RESEND notice (kind code 2, id 0) if the flag was set. Writing the current value changes nothing and issues no notice.
- R9: Writing an IPI priority above the previous one clears the resend flag and issues a RESEND notice if the flag was set. When both apply, the REJECT notice comes before the RESEND notice.
- R10: End-of-interrupt takes bits 31:24 of `eoi_word` as the new processor priority and applies the lowering path of R8 whatever the value. If bits 23:0 are not 2, an EOI notice (kind code 3) carrying those bits follows any RESEND notice.
- R11: At most one request is taken per cycle, in the priority order accept, end-of-interrupt, processor priority, IPI priority, deliver. A request is taken in a cycle where its valid and ready are both high. Ready is low whenever a higher-ranked valid is present.
- R12: A notice is held stable on `note_valid`, `note_kind` and `note_id` until `note_ready`. While any notice is outstanding every request ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Accept request |
| acc_ready | output | 1 | Accept can be taken this cycle |
| acc_word | output | 32 | Processor priority (31:24) and pending source id (23:0) |
| eoi_valid | input | 1 | End-of-interrupt request |
| eoi_word | input | 32 | New priority (31:24) and completed source id (23:0) |
| eoi_ready | output | 1 | End-of-interrupt can be taken |
| cppr_valid | input | 1 | Processor priority write |
| cppr_val | input | 8 | New processor priority |
| cppr_ready | output | 1 | Priority write can be taken |
| mfrr_valid | input | 1 | IPI priority write |
| mfrr_val | input | 8 | New IPI priority |
| mfrr_ready | output | 1 | IPI priority write can be taken |
| dlv_valid | input | 1 | Delivery request |
| dlv_id | input | 24 | Delivered source id |
| dlv_pri | input | 8 | Delivered priority |
| dlv_ready | output | 1 | Delivery can be taken |
| irq_out | output | 1 | Interrupt line to the processor |
| note_valid | output | 1 | Outbound notice present |
| note_kind | output | 2 | 1 REJECT, 2 RESEND, 3 EOI |
| note_id | output | 24 | Source id of the notice (0 for RESEND) |
| note_ready | input | 1 | Source controller takes the notice |

## Verification
A corrupted processor priority or pending id shows on `acc_word` in the cycle after the request that produced it. A wrong pending or IPI priority stays hidden until it flips `irq_out` or changes the outcome of the next delivery or accept. A wrong resend flag is the slowest fault to surface: it shows only at the next lowering write or IPI-priority raise, as a missing or extra RESEND notice. The bench therefore runs a long request sweep against a model, comparing `acc_word`, `irq_out` and the notice sequence after every request.

// File: rtl/ipp_pkg.sv
package ipp_pkg;
    parameter int PRI_W   = 8;
    parameter int ID_W    = 24;
    parameter int WORD_W  = PRI_W + ID_W;
    parameter int NUM_REQ = 5;

    // request slots, index 0 is the most favoured
    localparam int IX_ACC  = 0;
    localparam int IX_EOI  = 1;
    localparam int IX_CPPR = 2;
    localparam int IX_MFRR = 3;
    localparam int IX_DLV  = 4;

    localparam logic [ID_W-1:0] IPI_DEFAULT = ID_W'(2);

    typedef enum logic [1:0] {
        NK_NONE   = 2'd0,
        NK_REJECT = 2'd1,
        NK_RESEND = 2'd2,
        NK_EOI    = 2'd3
    } note_kind_e;

    typedef struct packed {
        logic [PRI_W-1:0] cppr;
        logic [PRI_W-1:0] mfrr;
        logic [PRI_W-1:0] ppri;
        logic [ID_W-1:0]  src;
        logic             nres;
    } pres_state_t;
endpackage

// File: rtl/ipp_arbiter.sv
module ipp_arbiter
    import ipp_pkg::*;
#(
    parameter int N = NUM_REQ
) (
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] avail,
    output logic [N-1:0] gnt
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        if (i == 0) begin : g_head
            assign avail[i] = en;
        end else begin : g_tail
            assign avail[i] = en & ~(|req[i-1:0]);
        end
    end

    assign gnt = avail & req;
endmodule

// File: rtl/ipp_core.sv
module ipp_core
    import ipp_pkg::*;
#(
    parameter logic [ID_W-1:0] IPI_ID = IPI_DEFAULT
) (
    input  pres_state_t        cur,
    input  logic [NUM_REQ-1:0] gnt,
    input  logic [WORD_W-1:0]  eoi_word,
    input  logic [PRI_W-1:0]   cppr_val,
    input  logic [PRI_W-1:0]   mfrr_val,
    input  logic [ID_W-1:0]    dlv_id,
    input  logic [PRI_W-1:0]   dlv_pri,
    output pres_state_t        nx,
    output logic               n1_v,
    output note_kind_e         n1_k,
    output logic [ID_W-1:0]    n1_id,
    output logic               n2_v,
    output note_kind_e         n2_k,
    output logic [ID_W-1:0]    n2_id
);
    logic              down;
    logic [PRI_W-1:0]  down_to;
    logic [ID_W-1:0]   rej_id;
    logic              rej_v;
    logic              res_v;
    logic              eoi_v;
    logic [ID_W-1:0]   eoi_id;
    logic              dlv_ok;

    assign dlv_ok = (dlv_pri < cur.cppr) && (dlv_pri < cur.mfrr) && (dlv_pri < cur.ppri);

    always_comb begin
        nx      = cur;
        down    = 1'b0;
        down_to = '0;
        rej_id  = '0;
        res_v   = 1'b0;
        eoi_v   = 1'b0;
        eoi_id  = '0;
        if (gnt[IX_ACC]) begin
            if (cur.src != '0) begin
                nx.cppr = cur.ppri;
                nx.src  = '0;
                nx.ppri = '1;
            end
        end else if (gnt[IX_EOI]) begin
            down    = 1'b1;
            down_to = eoi_word[WORD_W-1:ID_W];
            if (eoi_word[ID_W-1:0] != IPI_ID) begin
                eoi_v  = 1'b1;
                eoi_id = eoi_word[ID_W-1:0];
            end
        end else if (gnt[IX_CPPR]) begin
            if (cppr_val > cur.cppr) begin
                down    = 1'b1;
                down_to = cppr_val;
            end else if (cppr_val < cur.cppr) begin
                nx.cppr = cppr_val;
                if (cppr_val <= cur.ppri) begin
                    rej_id  = cur.src;
                    nx.src  = '0;
                    nx.ppri = '1;
                end
            end
        end else if (gnt[IX_MFRR]) begin
            nx.mfrr = mfrr_val;
            if ((mfrr_val < cur.cppr) && (mfrr_val <= cur.ppri)) begin
                rej_id  = cur.src;
                nx.ppri = mfrr_val;
                nx.src  = IPI_ID;
            end
            if (mfrr_val > cur.mfrr) begin
                res_v   = cur.nres;
                nx.nres = 1'b0;
            end
        end else if (gnt[IX_DLV]) begin
            if (dlv_ok) begin
                rej_id  = cur.src;
                nx.src  = dlv_id;
                nx.ppri = dlv_pri;
            end else begin
                nx.nres = 1'b1;
            end
        end

        // shared priority-lowering path
        if (down) begin
            nx.cppr = down_to;
            if ((cur.mfrr < down_to) && (cur.mfrr <= cur.ppri)) begin
                nx.ppri = cur.mfrr;
                nx.src  = IPI_ID;
            end
            res_v   = cur.nres;
            nx.nres = 1'b0;
        end
    end

    assign rej_v = (rej_id != '0) && (rej_id != IPI_ID);

    // notices leave in the fixed order REJECT, RESEND, EOI
    always_comb begin
        n1_v  = 1'b0;
        n1_k  = NK_NONE;
        n1_id = '0;
        n2_v  = 1'b0;
        n2_k  = NK_NONE;
        n2_id = '0;
        if (rej_v) begin
            n1_v  = 1'b1;
            n1_k  = NK_REJECT;
            n1_id = rej_id;
            if (res_v) begin
                n2_v = 1'b1;
                n2_k = NK_RESEND;
            end
        end else if (res_v) begin
            n1_v = 1'b1;
            n1_k = NK_RESEND;
            if (eoi_v) begin
                n2_v  = 1'b1;
                n2_k  = NK_EOI;
                n2_id = eoi_id;
            end
        end else if (eoi_v) begin
            n1_v  = 1'b1;
            n1_k  = NK_EOI;
            n1_id = eoi_id;
        end
    end
endmodule

// File: rtl/ipp_notice_fsm.sv
module ipp_notice_fsm
    import ipp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            in1_v,
    input  note_kind_e      in1_k,
    input  logic [ID_W-1:0] in1_id,
    input  logic            in2_v,
    input  note_kind_e      in2_k,
    input  logic [ID_W-1:0] in2_id,
    input  logic            note_ready,
    output logic            idle,
    output logic            note_valid,
    output logic [1:0]      note_kind,
    output logic [ID_W-1:0] note_id
);
    typedef enum logic [1:0] {
        NQ_IDLE = 2'd0,
        NQ_ONE  = 2'd1,
        NQ_TWO  = 2'd2
    } nq_state_e;

    nq_state_e       state_q;
    nq_state_e       state_d;
    note_kind_e      show_k;
    logic [ID_W-1:0] show_id;
    note_kind_e      wait_k;
    logic [ID_W-1:0] wait_id;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NQ_IDLE: if (load && in1_v) state_d = in2_v ? NQ_TWO : NQ_ONE;
            NQ_ONE:  if (note_ready) state_d = NQ_IDLE;
            NQ_TWO:  if (note_ready) state_d = NQ_ONE;
            default: state_d = NQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= NQ_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            show_k  <= NK_NONE;
            show_id <= '0;
            wait_k  <= NK_NONE;
            wait_id <= '0;
        end else begin
            unique case (state_q)
                NQ_IDLE: if (load && in1_v) begin
                    show_k  <= in1_k;
                    show_id <= in1_id;
                    wait_k  <= in2_k;
                    wait_id <= in2_id;
                end
                NQ_TWO: if (note_ready) begin
                    show_k  <= wait_k;
                    show_id <= wait_id;
                end
                default: ;
            endcase
        end
    end

    assign idle       = (state_q == NQ_IDLE);
    assign note_valid = (state_q != NQ_IDLE);
    assign note_kind  = show_k;
    assign note_id    = show_id;
endmodule

// File: rtl/ipp_presenter.sv
module ipp_presenter
    import ipp_pkg::*;
#(
    parameter logic [ID_W-1:0] IPI_ID = IPI_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    output logic              acc_ready,
    output logic [WORD_W-1:0] acc_word,
    input  logic              eoi_valid,
    input  logic [WORD_W-1:0] eoi_word,
    output logic              eoi_ready,
    input  logic              cppr_valid,
    input  logic [PRI_W-1:0]  cppr_val,
    output logic              cppr_ready,
    input  logic              mfrr_valid,
    input  logic [PRI_W-1:0]  mfrr_val,
    output logic              mfrr_ready,
    input  logic              dlv_valid,
    input  logic [ID_W-1:0]   dlv_id,
    input  logic [PRI_W-1:0]  dlv_pri,
    output logic              dlv_ready,
    output logic              irq_out,
    output logic              note_valid,
    output logic [1:0]        note_kind,
    output logic [ID_W-1:0]   note_id,
    input  logic              note_ready
);
    pres_state_t        st_q;
    pres_state_t        st_d;
    logic [NUM_REQ-1:0] req;
    logic [NUM_REQ-1:0] avail;
    logic [NUM_REQ-1:0] gnt;
    logic               idle;
    logic               n1_v, n2_v;
    note_kind_e         n1_k, n2_k;
    logic [ID_W-1:0]    n1_id, n2_id;

    always_comb begin
        req          = '0;
        req[IX_ACC]  = acc_valid;
        req[IX_EOI]  = eoi_valid;
        req[IX_CPPR] = cppr_valid;
        req[IX_MFRR] = mfrr_valid;
        req[IX_DLV]  = dlv_valid;
    end

    ipp_arbiter #(.N(NUM_REQ)) u_arb (
        .en    (idle),
        .req   (req),
        .avail (avail),
        .gnt   (gnt)
    );

    ipp_core #(.IPI_ID(IPI_ID)) u_core (
        .cur      (st_q),
        .gnt      (gnt),
        .eoi_word (eoi_word),
        .cppr_val (cppr_val),
        .mfrr_val (mfrr_val),
        .dlv_id   (dlv_id),
        .dlv_pri  (dlv_pri),
        .nx       (st_d),
        .n1_v     (n1_v),
        .n1_k     (n1_k),
        .n1_id    (n1_id),
        .n2_v     (n2_v),
        .n2_k     (n2_k),
        .n2_id    (n2_id)
    );

    ipp_notice_fsm u_nq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (|gnt),
        .in1_v      (n1_v),
        .in1_k      (n1_k),
        .in1_id     (n1_id),
        .in2_v      (n2_v),
        .in2_k      (n2_k),
        .in2_id     (n2_id),
        .note_ready (note_ready),
        .idle       (idle),
        .note_valid (note_valid),
        .note_kind  (note_kind),
        .note_id    (note_id)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cppr: '0, mfrr: '1, ppri: '1, src: '0, nres: 1'b0};
        end else if (|gnt) begin
            st_q <= st_d;
        end
    end

    assign acc_ready  = avail[IX_ACC];
    assign eoi_ready  = avail[IX_EOI];
    assign cppr_ready = avail[IX_CPPR];
    assign mfrr_ready = avail[IX_MFRR];
    assign dlv_ready  = avail[IX_DLV];
    assign acc_word   = {st_q.cppr, st_q.src};
    assign irq_out    = (st_q.src != '0) && (st_q.ppri < st_q.cppr);
endmodule

// File: rtl/ipp_presenter_chk.sv
module ipp_presenter_chk
    import ipp_pkg::*;
#(
    parameter logic [ID_W-1:0] IPI_ID = IPI_DEFAULT
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_ready,
    input logic [WORD_W-1:0] acc_word,
    input logic              eoi_valid,
    input logic [WORD_W-1:0] eoi_word,
    input logic              eoi_ready,
    input logic              cppr_valid,
    input logic [PRI_W-1:0]  cppr_val,
    input logic              cppr_ready,
    input logic              mfrr_valid,
    input logic              mfrr_ready,
    input logic              dlv_valid,
    input logic              dlv_ready,
    input logic              irq_out,
    input logic              note_valid,
    input logic [1:0]        note_kind,
    input logic [ID_W-1:0]   note_id,
    input logic              note_ready
);
    logic any_ready;
    assign any_ready = acc_ready | eoi_ready | cppr_ready | mfrr_ready | dlv_ready;

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (acc_word == '0) && !note_valid && !irq_out); // R1

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (acc_word[ID_W-1:0] != '0)); // R2

    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready) |=> (acc_word[ID_W-1:0] == '0)); // R5

    AST_ACCEPT_EMPTY_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && (acc_word[ID_W-1:0] == '0)) |=> $stable(acc_word)); // R5

    AST_REJECT_NOT_IPI: assert property (@(posedge clk) disable iff (!rst_n)
        (note_valid && (note_kind == NK_REJECT)) |-> ((note_id != IPI_ID) && (note_id != '0))); // R6

    AST_SAME_CPPR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cppr_valid && cppr_ready && (cppr_val == acc_word[WORD_W-1:ID_W]))
        |=> ($stable(acc_word) && !note_valid)); // R8

    AST_EOI_IPI_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && eoi_ready && (eoi_word[ID_W-1:0] == IPI_ID))
        |=> !(note_valid && (note_kind == NK_EOI))); // R10

    AST_ONE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_valid && acc_ready, eoi_valid && eoi_ready, cppr_valid && cppr_ready,
                  mfrr_valid && mfrr_ready, dlv_valid && dlv_ready})); // R11

    AST_NOTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (note_valid && !note_ready) |=> (note_valid && $stable(note_kind) && $stable(note_id))); // R12

    AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        note_valid |-> !any_ready); // R12
endmodule

bind ipp_presenter ipp_presenter_chk #(.IPI_ID(IPI_ID)) u_chk (.*);

// File: tb/ipp_presenter_test.sv
module ipp_presenter_test;
    localparam logic [23:0] IPI = 24'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 0, eoi_valid = 0, cppr_valid = 0, mfrr_valid = 0, dlv_valid = 0;
    logic [31:0] eoi_word = '0;
    logic [7:0]  cppr_val = '0, mfrr_val = '0, dlv_pri = '0;
    logic [23:0] dlv_id = '0;
    logic        note_ready = 1'b0;
    logic        acc_ready, eoi_ready, cppr_ready, mfrr_ready, dlv_ready, irq_out, note_valid;
    logic [31:0] acc_word;
    logic [1:0]  note_kind;
    logic [23:0] note_id;

    ipp_presenter #(.IPI_ID(IPI)) uut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_word(acc_word),
        .eoi_valid(eoi_valid), .eoi_word(eoi_word), .eoi_ready(eoi_ready),
        .cppr_valid(cppr_valid), .cppr_val(cppr_val), .cppr_ready(cppr_ready),
        .mfrr_valid(mfrr_valid), .mfrr_val(mfrr_val), .mfrr_ready(mfrr_ready),
        .dlv_valid(dlv_valid), .dlv_id(dlv_id), .dlv_pri(dlv_pri), .dlv_ready(dlv_ready),
        .irq_out(irq_out), .note_valid(note_valid), .note_kind(note_kind),
        .note_id(note_id), .note_ready(note_ready)
    );

    always #4 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;

    // reference model
    logic [7:0]  m_cppr, m_mfrr, m_ppri;
    logic [23:0] m_src;
    logic        m_nres;
    logic [1:0]  e_k  [0:1];
    logic [23:0] e_id [0:1];
    int          e_n;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] k, input logic [23:0] id);
        e_k[e_n]  = k;
        e_id[e_n] = id;
        e_n++;
    endtask

    task automatic m_reject(input logic [23:0] id);
        if (id != 0 && id != IPI) push(2'd1, id);
    endtask

    task automatic m_lower(input logic [7:0] v);
        m_cppr = v;
        if (m_mfrr < v && m_mfrr <= m_ppri) begin
            m_ppri = m_mfrr;
            m_src  = IPI;
        end
        if (m_nres) push(2'd2, 24'd0);
        m_nres = 1'b0;
    endtask

    function automatic logic ready_of(input int k);
        case (k)
            0: return acc_ready;
            1: return eoi_ready;
            2: return cppr_ready;
            3: return mfrr_ready;
            default: return dlv_ready;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n  = 1'b1;
        m_cppr = 8'h00; m_mfrr = 8'hFF; m_ppri = 8'hFF; m_src = '0; m_nres = 1'b0;
        check("R1 reset acc_word", acc_word, 32'h0);
        check("R1 reset irq_out", {31'd0, irq_out}, 32'd0);
        check("R1 reset note_valid", {31'd0, note_valid}, 32'd0);
        check("R1 reset acc_ready", {31'd0, acc_ready}, 32'd1);
    endtask

    // kind: 0 accept, 1 eoi, 2 cppr, 3 mfrr, 4 deliver
    task automatic op(input int kind, input logic [31:0] w, input logic [7:0] p);
        string       tag;
        logic [7:0]  old_mfrr;
        e_n = 0;
        case (kind)
            0: tag = "R5";
            1: tag = "R10";
            2: tag = (p < m_cppr) ? "R7" : "R8";
            3: tag = "R9";
            default: tag = "R3";
        endcase
        @(negedge clk);
        case (kind)
            0: acc_valid = 1'b1;
            1: begin eoi_valid = 1'b1; eoi_word = w; end
            2: begin cppr_valid = 1'b1; cppr_val = p; end
            3: begin mfrr_valid = 1'b1; mfrr_val = p; end
            default: begin dlv_valid = 1'b1; dlv_id = w[23:0]; dlv_pri = p; end
        endcase
        #1;
        check({"R11 ready ", tag}, {31'd0, ready_of(kind)}, 32'd1);
        if (kind == 0) check("R5 accept word", acc_word, {m_cppr, m_src});
        @(posedge clk);
        #1;
        acc_valid = 0; eoi_valid = 0; cppr_valid = 0; mfrr_valid = 0; dlv_valid = 0;
        case (kind)
            0: if (m_src != 0) begin
                   m_cppr = m_ppri; m_src = '0; m_ppri = 8'hFF;
               end
            1: begin
                   m_lower(w[31:24]);
                   if (w[23:0] != IPI) push(2'd3, w[23:0]);
               end
            2: if (p > m_cppr) m_lower(p);
               else if (p < m_cppr) begin
                   m_cppr = p;
                   if (p <= m_ppri) begin
                       m_reject(m_src); m_src = '0; m_ppri = 8'hFF;
                   end
               end
            3: begin
                   old_mfrr = m_mfrr;
                   m_mfrr = p;
                   if (p < m_cppr && p <= m_ppri) begin
                       m_reject(m_src); m_ppri = p; m_src = IPI;
                   end
                   if (p > old_mfrr) begin
                       if (m_nres) push(2'd2, 24'd0);
                       m_nres = 1'b0;
                   end
               end
            default: if (p < m_cppr && p < m_mfrr && p < m_ppri) begin
                         m_reject(m_src); m_src = w[23:0]; m_ppri = p;
                     end else m_nres = 1'b1;
        endcase
        @(negedge clk);
        check({tag, " acc_word"}, acc_word, {m_cppr, m_src});
        check({"R2 irq_out after ", tag}, {31'd0, irq_out},
              {31'd0, (m_src != 0 && m_ppri < m_cppr)});
        for (int i = 0; i < e_n; i++) begin
            check({"R12 note_valid ", tag}, {31'd0, note_valid}, 32'd1);
            check({"R12 busy blocks ", tag}, {31'd0, acc_ready}, 32'd0);
            check({tag, " note_kind"}, {30'd0, note_kind}, {30'd0, e_k[i]});
            check({tag, " note_id"}, {8'd0, note_id}, {8'd0, e_id[i]});
            if (i == 0) begin
                @(negedge clk);
                check("R12 held kind", {30'd0, note_kind}, {30'd0, e_k[i]});
                check("R12 held id", {8'd0, note_id}, {8'd0, e_id[i]});
            end
            note_ready = 1'b1;
            @(negedge clk);
            note_ready = 1'b0;
        end
        check({"R12 drained ", tag}, {31'd0, note_valid}, 32'd0);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        do_reset();

        // R4: at reset priority 0 no delivery can succeed; flag is set
        op(4, 32'h40, 8'h05);
        check("R4 slot unchanged", acc_word, 32'h0);
        // R8: lowering emits the resend that R4 latched
        op(2, 32'h0, 8'h08);
        // R6: IPI pending once its priority is below the processor priority
        op(3, 32'h0, 8'h04);
        check("R6 ipi pending", acc_word, {8'h08, IPI});
        // R3: delivery displaces the IPI without a REJECT notice (R6)
        op(4, 32'h55, 8'h03);
        // R7: raising to 3 displaces id 0x55
        op(2, 32'h0, 8'h03);
        // R8: same value, nothing happens
        op(2, 32'h0, 8'h03);
        // R10: end-of-interrupt with and without the IPI id
        op(1, {8'h0A, 24'h77}, 8'h0);
        op(1, {8'h0A, IPI}, 8'h0);
        op(0, 32'h0, 8'h0);

        // R11: static arbitration check, no take happens before the edge
        @(negedge clk);
        acc_valid = 1; cppr_valid = 1; dlv_valid = 1;
        #1;
        check("R11 acc wins", {29'd0, acc_ready, cppr_ready, dlv_ready}, 32'b100);
        acc_valid = 0;
        #1;
        check("R11 cppr over dlv", {29'd0, acc_ready, cppr_ready, dlv_ready}, 32'b110);
        cppr_valid = 0; dlv_valid = 0;

        // near-exhaustive sweep of delivery against priority settings
        for (int c = 0; c < 3; c++) begin
            for (int m = 0; m < 3; m++) begin
                for (int p = 0; p < 16; p++) begin
                    do_reset();
                    op(2, 32'h0, (c == 0) ? 8'h04 : (c == 1) ? 8'h08 : 8'h10);
                    op(3, 32'h0, (m == 0) ? 8'h03 : (m == 1) ? 8'h09 : 8'hFF);
                    op(4, 32'h100 + p, 8'(p));
                    op(4, 32'h200 + p, 8'(p ^ 5));
                    op(0, 32'h0, 8'h0);
                end
            end
        end

        // pseudo-random request stream
        do_reset();
        r = 32'h1D2C_3B4A;
        for (int i = 0; i < 600; i++) begin
            logic [7:0]  pv;
            logic [23:0] idv;
            r = r ^ (r << 13);
            r = r ^ (r >> 17);
            r = r ^ (r << 5);
            pv  = (r[14:12] == 3'd0) ? 8'hFF : {4'd0, r[11:8]};
            idv = r[16] ? IPI : (24'h100 + {20'd0, r[23:20]});
            case (r[2:0] % 5)
                0: op(0, 32'h0, 8'h0);
                1: op(1, {pv, idv}, 8'h0);
                2: op(2, 32'h0, pv);
                3: op(3, 32'h0, pv);
                default: op(4, {8'h0, 24'h100 + {20'd0, r[23:20]}}, pv);
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule